// File: doc/BRIEF.md
# Power-On Reset and Strap Sequencer

This block is a reset sequencer for a board-level controller. It runs on a clock taken from the same source as the processor's system clock. Two power-good inputs, one for the core rail and one for the platform rail, pass through two-flop synchronizers. The processor's power-on reset output stays low from the moment the controller's own reset is asserted. It rises only after both rails have been good for a programmable number of clock cycles. That count is set long enough to cover the processor's PLL lock interval. While reset is low, the block drives a set of configuration straps with values captured just before the delay starts. Once reset is released, it lets go of the straps a fixed number of cycles later, inside the narrow window in which the processor still samples them and before those pins change to their bus function.

The processor's hard-reset line is shared by the processor and other agents. The block treats it as open drain: it either pulls the line low or leaves it released, and an external pull-up is assumed. The block pulls the line low only while the power-on reset is held. After the straps are released, it samples the line through a synchronizer. It reports boot progress once the line has read high for four consecutive cycles, and it withdraws that report when any agent holds the line low to stall boot. A chip reset is requested only through the power-on reset path, using a one-cycle request input.

Top module: `rst_strap_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `por_n` is 0, `strap_oe` is 1, `hrst_drive_low` is 1 and `boot_done` is 0.
- R2: `por_n` stays 0 while either power-good input is low. When the second power-good input goes high before clock edge e0, `por_n` reads 1 first after edge e0+PG_DLY+2 (two synchronizer cycles, one state cycle, then PG_DLY cycles of delay).
- R3: `strap_o` holds the `strap_cfg` value sampled in the last cycle before the delay count begins. Changes to `strap_cfg` after that have no effect on `strap_o` until the sequence restarts.
- R4: `strap_oe` falls exactly REL_CYC cycles after `por_n` rises. REL_CYC defaults to 3 and must lie between 2 and 5.
- R5: `hrst_drive_low` is 1 exactly while `por_n` is 0. From the cycle in which `por_n` rises, the line is only released and never driven.
- R6: After the straps are released, `boot_done` rises in the fourth consecutive cycle in which the synchronized hard-reset line reads high. A line released before edge e0 gives `boot_done` = 1 first after edge e0+5, and a high pulse shorter than four cycles never sets it.
- R7: In the boot-done state, the line held low before edge e0 clears `boot_done` after edge e0+2. `por_n` is left high during such a stall.
- R8: A power-good input that drops in any state drives `por_n` to 0, `strap_oe` to 1, `hrst_drive_low` to 1 and `boot_done` to 0 after the third clock edge, and the full delay restarts.
- R9: A one-cycle `rst_req` pulse before edge e0 forces `por_n` to 0, `strap_oe` to 1, `hrst_drive_low` to 1 and `boot_done` to 0 after edge e0. With both rails good, `por_n` rises again after edge e0+PG_DLY+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, same source as the processor system clock |
| rst_n | input | 1 | Active-low asynchronous reset of the controller |
| pg_core | input | 1 | Core rail power-good, asynchronous |
| pg_plat | input | 1 | Platform rail power-good, asynchronous |
| rst_req | input | 1 | Synchronous single-cycle chip reset request |
| strap_cfg | input | STRAP_W | Configuration values to present on the strap pins |
| hrst_in | input | 1 | Sampled level of the shared hard-reset line |
| por_n | output | 1 | Power-on reset to the processor, active low |
| strap_o | output | STRAP_W | Strap pin output values |
| strap_oe | output | 1 | Strap pin output enable |
| hrst_drive_low | output | 1 | Pull the hard-reset line low when 1, release it when 0 |
| boot_done | output | 1 | Boot has progressed past the hard-reset phase |

## Verification
The strap release and the start of hard-reset sampling can fall in the same cycle. This happens when the shared line is already released at the moment the straps let go, as after a reset request in which no agent holds the line. The bench runs a reset request with the line already free. It then expects `boot_done` exactly four cycles after the strap enable falls, with no extra cycle lost at the handover. A second overlap is a rail dropping while boot is reported. The bench removes power-good in the boot-done state and expects every output to return to its reset level on the same edge.

// File: rtl/rss_pkg.sv
package rss_pkg;

  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_WAIT  = 3'd1,
    ST_HOLD  = 3'd2,
    ST_BOOT  = 3'd3,
    ST_DONE  = 3'd4
  } seq_st_e;

  // bits needed to count from 0 up to lim-1
  function automatic int unsigned cnt_bits(input int unsigned lim);
    return (lim < 3) ? 1 : $clog2(lim);
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic por_released(input seq_st_e s);
    return (s == ST_HOLD) || (s == ST_BOOT) || (s == ST_DONE);
  endfunction

  function automatic logic straps_driven(input seq_st_e s);
    return (s == ST_RESET) || (s == ST_WAIT) || (s == ST_HOLD);
  endfunction

endpackage

// File: rtl/rss_sync.sv
module rss_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stg
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rss_cnt.sv
module rss_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (clr) q <= '0;
    else if (inc) q <= q + W'(1);
  end
endmodule

// File: rtl/rss_fsm.sv
module rss_fsm
  import rss_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pg_ok,
  input  logic    rst_req,
  input  logic    ph_last,
  input  logic    hi_last,
  input  logic    hrst_hi,
  output seq_st_e st,
  output logic    st_chg
);
  seq_st_e nx;

  always_comb begin
    nx = st;
    if (!pg_ok || rst_req) begin
      nx = ST_RESET;
    end else begin
      case (st)
        ST_RESET: nx = ST_WAIT;
        ST_WAIT:  if (ph_last)  nx = ST_HOLD;
        ST_HOLD:  if (ph_last)  nx = ST_BOOT;
        ST_BOOT:  if (hi_last)  nx = ST_DONE;
        ST_DONE:  if (!hrst_hi) nx = ST_BOOT;
        default:  nx = ST_RESET;
      endcase
    end
  end

  assign st_chg = (nx != st);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_RESET;
    else        st <= nx;
  end
endmodule

// File: rtl/rst_strap_seq.sv
module rst_strap_seq
  import rss_pkg::*;
#(
  parameter int unsigned STRAP_W = 8,
  parameter int unsigned PG_DLY  = 10000,
  parameter int unsigned REL_CYC = 3,
  parameter int unsigned HI_N    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pg_core,
  input  logic               pg_plat,
  input  logic               rst_req,
  input  logic [STRAP_W-1:0] strap_cfg,
  input  logic               hrst_in,
  output logic               por_n,
  output logic [STRAP_W-1:0] strap_o,
  output logic               strap_oe,
  output logic               hrst_drive_low,
  output logic               boot_done
);
  localparam int unsigned PH_W = cnt_bits(max2(PG_DLY, REL_CYC));
  localparam int unsigned HI_W = cnt_bits(HI_N);

  // synchronized inputs
  logic [1:0] pg_s;
  logic       pg_ok_s;
  logic       hrst_hi;

  rss_sync #(.W(2), .STAGES(2)) u_pg_sync (
    .clk(clk), .rst_n(rst_n), .d({pg_plat, pg_core}), .q(pg_s)
  );
  rss_sync #(.W(1), .STAGES(2)) u_hr_sync (
    .clk(clk), .rst_n(rst_n), .d(hrst_in), .q(hrst_hi)
  );
  assign pg_ok_s = &pg_s;

  // state machine
  seq_st_e st;
  logic    st_chg;
  logic    ph_last;
  logic    hi_last;

  rss_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .pg_ok(pg_ok_s), .rst_req(rst_req),
    .ph_last(ph_last), .hi_last(hi_last), .hrst_hi(hrst_hi),
    .st(st), .st_chg(st_chg)
  );

  // phase counter: delay after power-good, then strap hold
  logic [PH_W-1:0] ph_cnt;
  logic [PH_W-1:0] ph_lim_m1;
  logic            ph_run;

  assign ph_run = (st == ST_WAIT) || (st == ST_HOLD);

  always_comb begin
    case (st)
      ST_WAIT: ph_lim_m1 = PH_W'(PG_DLY - 1);
      ST_HOLD: ph_lim_m1 = PH_W'(REL_CYC - 1);
      default: ph_lim_m1 = '0;
    endcase
  end

  rss_cnt #(.W(PH_W)) u_ph_cnt (
    .clk(clk), .rst_n(rst_n), .clr(st_chg), .inc(ph_run), .q(ph_cnt)
  );
  assign ph_last = ph_run && (ph_cnt == ph_lim_m1);

  // consecutive-high counter on the shared hard-reset line
  logic [HI_W-1:0] hi_cnt;
  logic            hi_run;

  assign hi_run = (st == ST_BOOT) && hrst_hi;

  rss_cnt #(.W(HI_W)) u_hi_cnt (
    .clk(clk), .rst_n(rst_n), .clr(!hi_run), .inc(1'b1), .q(hi_cnt)
  );
  assign hi_last = hi_run && (hi_cnt == HI_W'(HI_N - 1));

  // strap capture: tracks the input only in the reset state
  logic [STRAP_W-1:0] strap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               strap_q <= '0;
    else if (st == ST_RESET)  strap_q <= strap_cfg;
  end

  // named events for the checker
  logic ev_dly_done;
  logic ev_frozen;
  assign ev_dly_done = (st == ST_WAIT) && ph_last;
  assign ev_frozen   = ph_run;

  // outputs decoded from the state register
  assign por_n          = por_released(st);
  assign strap_oe       = straps_driven(st);
  assign strap_o        = strap_q;
  assign hrst_drive_low = !por_released(st);
  assign boot_done      = (st == ST_DONE);
endmodule

// File: rtl/rst_strap_seq_chk.sv
module rst_strap_seq_chk #(
  parameter int unsigned STRAP_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pg_ok_s,
  input logic               rst_req,
  input logic               hrst_hi,
  input logic               ev_dly_done,
  input logic               ev_frozen,
  input logic               por_n,
  input logic               strap_oe,
  input logic [STRAP_W-1:0] strap_o,
  input logic               hrst_drive_low,
  input logic               boot_done
);
  // cycles spent with reset released and straps still driven
  logic [3:0] rel_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           rel_cnt <= '0;
    else if (!por_n)                      rel_cnt <= '0;
    else if (strap_oe && rel_cnt != 4'hF) rel_cnt <= rel_cnt + 4'd1;
  end

  p_rail_low_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_ok_s |=> !por_n);

  p_por_after_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_n) |-> $past(ev_dly_done));

  p_strap_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frozen && $past(ev_frozen)) |-> $stable(strap_o));

  p_strap_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strap_oe) |-> (rel_cnt >= 4'd2 && rel_cnt <= 4'd5));

  p_strap_release_por_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strap_oe) |-> por_n);

  p_hrst_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_n) |-> !hrst_drive_low);

  p_done_needs_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boot_done) |-> (!strap_oe && $past(hrst_hi)));

  p_stall_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_done && !hrst_hi && pg_ok_s) |=> (!boot_done && por_n));

  p_rail_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_ok_s |=> (strap_oe && hrst_drive_low && !boot_done));

  p_req_resets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> (!por_n && strap_oe && !boot_done));
endmodule

bind rst_strap_seq rst_strap_seq_chk #(.STRAP_W(STRAP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pg_ok_s(pg_ok_s), .rst_req(rst_req),
  .hrst_hi(hrst_hi), .ev_dly_done(ev_dly_done), .ev_frozen(ev_frozen),
  .por_n(por_n), .strap_oe(strap_oe), .strap_o(strap_o),
  .hrst_drive_low(hrst_drive_low), .boot_done(boot_done)
);

// File: tb/rst_strap_seq_tb_top.sv
module rst_strap_seq_tb_top;
  localparam int W   = 8;
  localparam int DLY = 20;
  localparam int REL = 3;

  localparam int S_POR  = 0;
  localparam int S_OE   = 1;
  localparam int S_VAL  = 2;
  localparam int S_HRST = 3;
  localparam int S_DONE = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n, pg_core, pg_plat, rst_req, dev_hold;
  logic [W-1:0] cfg;
  logic         por_n, strap_oe, drv_low, boot_done;
  logic [W-1:0] strap_o;
  logic         hrst_line;

  // open-drain wire with pull-up: low if anyone pulls
  assign hrst_line = !(drv_low | dev_hold);

  rst_strap_seq #(.STRAP_W(W), .PG_DLY(DLY), .REL_CYC(REL), .HI_N(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .pg_core(pg_core), .pg_plat(pg_plat),
    .rst_req(rst_req), .strap_cfg(cfg), .hrst_in(hrst_line),
    .por_n(por_n), .strap_o(strap_o), .strap_oe(strap_oe),
    .hrst_drive_low(drv_low), .boot_done(boot_done)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    int    sig;
    int    val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   nvec  = 0;
  int   nfail = 0;

  function automatic int peek(input int sig);
    case (sig)
      S_POR:   return int'(por_n);
      S_OE:    return int'(strap_oe);
      S_VAL:   return int'(strap_o);
      S_HRST:  return int'(drv_low);
      default: return int'(boot_done);
    endcase
  endfunction

  function automatic string sname(input int sig);
    case (sig)
      S_POR:   return "por_n";
      S_OE:    return "strap_oe";
      S_VAL:   return "strap_o";
      S_HRST:  return "hrst_drive_low";
      default: return "boot_done";
    endcase
  endfunction

  // driver side: insert expected item keeping the queue ordered by cycle
  task automatic expect_at(input int at, input int sig, input int val, input string tag);
    exp_t e;
    int   pos;
    e.at = at; e.sig = sig; e.val = val; e.tag = tag;
    pos = q.size();
    for (int i = 0; i < q.size(); i++) begin
      if (q[i].at > at) begin pos = i; break; end
    end
    q.insert(pos, e);
  endtask

  // monitor side: compare mid-cycle, away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      int   act;
      e = q.pop_front();
      nvec++;
      act = peek(e.sig);
      if (e.at != cyc) begin
        nfail++;
        $display("FAIL %s: %s check at cycle %0d missed (actual cycle %0d, expected %0d)",
                 e.tag, sname(e.sig), e.at, cyc, e.at);
      end else if (act != e.val) begin
        nfail++;
        $display("FAIL %s: %s at cycle %0d actual=%0h expected=%0h",
                 e.tag, sname(e.sig), cyc, act, e.val);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    while (q.size() > 0) tick(1);
  endtask

  task automatic run_all();
    int n, m, p;
    // R1: reset state
    rst_n = 1'b0; pg_core = 1'b0; pg_plat = 1'b0; rst_req = 1'b0;
    dev_hold = 1'b1; cfg = 8'hA5;
    tick(3);
    expect_at(cyc + 1, S_POR, 0, "R1");
    expect_at(cyc + 1, S_OE, 1, "R1");
    expect_at(cyc + 1, S_HRST, 1, "R1");
    expect_at(cyc + 1, S_DONE, 0, "R1");
    rst_n = 1'b1;
    tick(1);
    expect_at(cyc + 1, S_POR, 0, "R1");
    expect_at(cyc + 1, S_HRST, 1, "R1");
    drain();

    // R2: one rail alone keeps reset low
    pg_core = 1'b1;
    n = cyc;
    expect_at(n + DLY + 5, S_POR, 0, "R2");
    tick(DLY + 6);

    // R2/R3/R4/R5: second rail good starts the delay
    pg_plat = 1'b1;
    n = cyc;
    p = n + DLY + 3;
    expect_at(p - 1, S_POR, 0, "R2");
    expect_at(p, S_POR, 1, "R2");
    expect_at(p, S_VAL, 8'hA5, "R3");
    expect_at(p - 1, S_HRST, 1, "R5");
    expect_at(p, S_HRST, 0, "R5");
    expect_at(p + REL - 1, S_OE, 1, "R4");
    expect_at(p + REL, S_OE, 0, "R4");
    tick(5);
    cfg = 8'h3C;  // after capture: must not reach the pins (R3)
    drain();
    tick(4);

    // R6: short release is not enough
    dev_hold = 1'b0;
    n = cyc;
    tick(2);
    dev_hold = 1'b1;
    expect_at(n + 6, S_DONE, 0, "R6");
    expect_at(n + 8, S_DONE, 0, "R6");
    drain();
    tick(2);

    // R6: full release
    dev_hold = 1'b0;
    n = cyc;
    expect_at(n + 5, S_DONE, 0, "R6");
    expect_at(n + 6, S_DONE, 1, "R6");
    drain();
    tick(2);

    // R7: stall by an external agent
    dev_hold = 1'b1;
    n = cyc;
    expect_at(n + 2, S_DONE, 1, "R7");
    expect_at(n + 3, S_DONE, 0, "R7");
    expect_at(n + 3, S_POR, 1, "R7");
    drain();
    tick(2);
    dev_hold = 1'b0;
    n = cyc;
    expect_at(n + 6, S_DONE, 1, "R6");
    drain();
    tick(2);

    // R9: reset request; line is free, so strap release and sampling overlap
    rst_req = 1'b1;
    n = cyc;
    p = n + DLY + 2;
    expect_at(n + 1, S_POR, 0, "R9");
    expect_at(n + 1, S_OE, 1, "R9");
    expect_at(n + 1, S_HRST, 1, "R9");
    expect_at(n + 1, S_DONE, 0, "R9");
    expect_at(p - 1, S_POR, 0, "R9");
    expect_at(p, S_POR, 1, "R9");
    expect_at(p, S_VAL, 8'h3C, "R3");
    expect_at(p + REL, S_OE, 0, "R4");
    expect_at(p + REL + 3, S_DONE, 0, "R6");
    expect_at(p + REL + 4, S_DONE, 1, "R6");
    tick(1);
    rst_req = 1'b0;
    drain();
    tick(2);

    // R8: rail drop while boot is reported
    pg_core = 1'b0;
    n = cyc;
    expect_at(n + 2, S_POR, 1, "R8");
    expect_at(n + 2, S_DONE, 1, "R8");
    expect_at(n + 3, S_POR, 0, "R8");
    expect_at(n + 3, S_OE, 1, "R8");
    expect_at(n + 3, S_HRST, 1, "R8");
    expect_at(n + 3, S_DONE, 0, "R8");
    drain();
    tick(3);

    // R8: rail drop during the delay restarts it
    pg_core = 1'b1;
    n = cyc;
    tick(DLY / 2);
    pg_plat = 1'b0;
    expect_at(n + DLY + 3, S_POR, 0, "R8");
    drain();
    tick(3);
    pg_plat = 1'b1;
    m = cyc;
    expect_at(m + DLY + 2, S_POR, 0, "R2");
    expect_at(m + DLY + 3, S_POR, 1, "R2");
    drain();
    tick(4);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog (R1..all): actual=timeout expected=completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule